// File: doc/BRIEF.md
# Pin-Sampled Remainder-of-Three Tracker

This block rebuilds a tiny Mealy machine whose clock, reset and data arrive on ordinary input pins. A much faster system clock samples the three pins through two-flop synchronisers. The block remembers the last sampled level of each pin and reacts only when a level changes. The machine follows the remainder, modulo 3, of a bit stream that arrives most significant bit first. One output bit reports a Mealy function of the current remainder and the data pin.

The remainder register loads only on a low-to-high transition of the pin clock. Any change on the pin reset or the data pin recomputes the pending next remainder and the output. A high pin reset forces the pending next remainder to zero and leaves the output unchanged. The remainder itself reaches zero only at the next rising pin clock. Next remainder and output come from a six-entry lookup indexed by twice the remainder plus the data bit.

Top module: `mod3_pin_fsm`

## Requirements
- R1: After the system reset (rst_sys_n low), dout_o is 0, and the remainder, the pending next remainder and the stored pin levels are all 0.
- R2: The pending next remainder is (2 x remainder + data) mod 3 and always lies in 0..2. It comes from a lookup at index 2 x remainder + data with entries 0x10, 0x01, 0x02, 0x00, 0x01, 0x12 for indices 0 to 5, next remainder in bits 1:0 and output in bit 4.
- R3: When recomputed outside reset, dout_o is 1 exactly when the remainder is 0 with data 0, or the remainder is 2 with data 1, and 0 otherwise.
- R4: The remainder loads the pending next remainder only when the sampled pin clock goes from 0 to 1. A 1-to-0 transition only updates the stored clock level and leaves dout_o unchanged.
- R5: In the cycle that the remainder updates on a rising pin clock, the pending next remainder and dout_o are recomputed from the new remainder and the current data level.
- R6: A change in the sampled pin reset or data level triggers a recompute. With no rising pin clock and no such change, the pending next remainder and dout_o hold.
- R7: While the sampled pin reset is 1, a recompute sets the pending next remainder to 0 and leaves dout_o unchanged. The remainder becomes 0 at the next rising pin clock.
- R8: Each pin passes through two system-clock flops. A pin change made between system clock edges shows on dout_o after the third following rising system clock edge and not before.
- R9: When the pin clock rises and the data or reset level changes in the same system cycle, the clock transition is handled first and the recompute uses the new remainder and the new levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System sampling clock |
| rst_sys_n | input | 1 | Asynchronous active-low system reset |
| pin_clk_i | input | 1 | Pin clock, treated as sampled data |
| pin_rst_i | input | 1 | Pin reset, active high |
| pin_din_i | input | 1 | Pin data bit, most significant first |
| dout_o | output | 1 | Mealy output bit |

## Verification
A pin change made between system clock edges passes two synchroniser flops and then the change detector and remainder logic, so dout_o is due just after the third rising system edge that follows. The driver waits for exactly three rising edges after every pin change before it hands the expected output to the scoreboard, and the monitor compares it at the next falling edge, when dout_o is stable. For R8 the driver also checks that dout_o still holds its old value after the second edge. The expected values come from a reference model that replays the pin events in clock-first order, computes the arithmetic form of the rules, and holds the output while the pin reset is high.

// File: rtl/mod3_pkg.sv
package mod3_pkg;

  localparam int REM_W    = 2;
  localparam int IDX_W    = 3;
  localparam int ENTRY_W  = 5;
  localparam int OUT_BIT  = 4;
  localparam int NUM_PINS = 3;

  typedef enum int {
    PIN_CLK = 0,
    PIN_RST = 1,
    PIN_DIN = 2
  } pin_sel_e;

  typedef logic [REM_W-1:0]   rem_t;
  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [ENTRY_W-1:0] entry_t;

  // Table index: twice the remainder plus the data bit.
  function automatic idx_t step_index(input rem_t rem, input logic bit_in);
    return idx_t'({rem, 1'b0}) + idx_t'(bit_in);
  endfunction

  // Six-entry step table: next remainder in the low bits, output in OUT_BIT.
  function automatic entry_t step_lookup(input idx_t idx);
    entry_t e;
    case (idx)
      3'd0:    e = 5'h10;
      3'd1:    e = 5'h01;
      3'd2:    e = 5'h02;
      3'd3:    e = 5'h00;
      3'd4:    e = 5'h01;
      3'd5:    e = 5'h12;
      default: e = 5'h00;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int LAST = STAGES - 1;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else if (STAGES == 1) chain_q <= async_i[g];
        else chain_q <= {chain_q[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = chain_q[LAST];
    end
  endgenerate

endmodule

// File: rtl/pin_change_detect.sv
module pin_change_detect
  import mod3_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic                clk_rise_o,
  output logic                data_chg_o
);

  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign clk_rise_o = lvl_i[PIN_CLK] & ~prev_q[PIN_CLK];
  assign data_chg_o = (lvl_i[PIN_RST] ^ prev_q[PIN_RST]) |
                      (lvl_i[PIN_DIN] ^ prev_q[PIN_DIN]);

  // R4: stored levels always follow the sampled levels one cycle later.
  p_prev_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(lvl_i));

  // R1: stored levels are zero while the system reset is held.
  always_comb begin
    if (!rst_n) p_prev_reset_r1: assert (prev_q == '0);
  end

endmodule

// File: rtl/mod3_step_core.sv
module mod3_step_core
  import mod3_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clk_rise_i,
  input  logic data_chg_i,
  input  logic rst_lvl_i,
  input  logic din_lvl_i,
  output logic dout_o
);

  rem_t   rem_q, nxt_q, rem_eff, nxt_d;
  logic   dout_q, dout_d;
  logic   recompute;
  entry_t entry;

  always_comb begin
    rem_eff   = clk_rise_i ? nxt_q : rem_q;
    recompute = clk_rise_i | data_chg_i;
    entry     = step_lookup(step_index(rem_eff, din_lvl_i));
    nxt_d     = nxt_q;
    dout_d    = dout_q;
    if (recompute) begin
      if (rst_lvl_i) begin
        nxt_d = '0;
      end else begin
        nxt_d  = entry[REM_W-1:0];
        dout_d = entry[OUT_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      nxt_q  <= '0;
      dout_q <= 1'b0;
    end else begin
      rem_q  <= rem_eff;
      nxt_q  <= nxt_d;
      dout_q <= dout_d;
    end
  end

  assign dout_o = dout_q;

  // R4: the remainder moves only on a rising pin clock.
  p_rem_only_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rise_i |=> $stable(rem_q));

  // R2: remainder and pending value stay in 0..2.
  p_rem_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rem_q != 2'd3) && (nxt_q != 2'd3));

  // R6: no event, no change of pending value or output.
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rise_i && !data_chg_i |=> $stable(nxt_q) && $stable(dout_q));

  // R7: pin reset high forces pending zero and holds the output.
  p_reset_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_lvl_i |=> (nxt_q == '0) && $stable(dout_q));

  // R3 / R5: recomputed output follows the Mealy rule on the updated remainder.
  p_dout_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise_i || data_chg_i) && !rst_lvl_i |=>
      dout_q == ((rem_q == 2'd0 && !$past(din_lvl_i)) ||
                 (rem_q == 2'd2 &&  $past(din_lvl_i))));

  // R2: arithmetic form of the pending value outside reset.
  p_next_arith_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_rise_i || data_chg_i) && !rst_lvl_i |=>
      int'(nxt_q) == (2 * int'(rem_q) + int'($past(din_lvl_i))) % 3);

endmodule

// File: rtl/mod3_pin_fsm.sv
module mod3_pin_fsm
  import mod3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_sys,
  input  logic rst_sys_n,
  input  logic pin_clk_i,
  input  logic pin_rst_i,
  input  logic pin_din_i,
  output logic dout_o
);

  logic [NUM_PINS-1:0] raw_pins;
  logic [NUM_PINS-1:0] sync_pins;
  logic                clk_rise;
  logic                data_chg;

  always_comb begin
    raw_pins          = '0;
    raw_pins[PIN_CLK] = pin_clk_i;
    raw_pins[PIN_RST] = pin_rst_i;
    raw_pins[PIN_DIN] = pin_din_i;
  end

  pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk_sys),
    .rst_n   (rst_sys_n),
    .async_i (raw_pins),
    .sync_o  (sync_pins)
  );

  pin_change_detect u_detect (
    .clk        (clk_sys),
    .rst_n      (rst_sys_n),
    .lvl_i      (sync_pins),
    .clk_rise_o (clk_rise),
    .data_chg_o (data_chg)
  );

  mod3_step_core u_core (
    .clk        (clk_sys),
    .rst_n      (rst_sys_n),
    .clk_rise_i (clk_rise),
    .data_chg_i (data_chg),
    .rst_lvl_i  (sync_pins[PIN_RST]),
    .din_lvl_i  (sync_pins[PIN_DIN]),
    .dout_o     (dout_o)
  );

  // R8: a synchronised level equals the pin value from two edges back.
  p_sync_delay_r8: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
    $past(rst_sys_n, 2) |=> sync_pins == $past(raw_pins, 2));

  // R1: output low during system reset.
  always_comb begin
    if (!rst_sys_n) p_dout_reset_r1: assert (dout_o == 1'b0);
  end

endmodule

// File: tb/mod3_pin_fsm_bench.sv
`timescale 1ns/1ps
module mod3_pin_fsm_bench;

  logic clk_sys = 1'b0;
  logic rst_sys_n = 1'b0;
  logic pin_clk_i = 1'b0;
  logic pin_rst_i = 1'b0;
  logic pin_din_i = 1'b0;
  logic dout_o;

  always #2 clk_sys = ~clk_sys;

  mod3_pin_fsm u_mod3_pin_fsm (
    .clk_sys   (clk_sys),
    .rst_sys_n (rst_sys_n),
    .pin_clk_i (pin_clk_i),
    .pin_rst_i (pin_rst_i),
    .pin_din_i (pin_din_i),
    .dout_o    (dout_o)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t sb_q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state.
  int   m_rem = 0, m_nxt = 0;
  logic m_dout = 0, m_oc = 0, m_or = 0, m_od = 0;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic model_recompute(input logic r, input logic d);
    m_or = r;
    m_od = d;
    if (r) m_nxt = 0;
    else begin
      m_nxt  = (2 * m_rem + int'(d)) % 3;
      m_dout = (m_rem == 0 && d == 0) || (m_rem == 2 && d == 1);
    end
  endtask

  // Driver: change pins at a falling edge, update model clock-first, push result.
  task automatic drive(input logic c, input logic r, input logic d,
                       input string tag, input bit lat_chk);
    logic old;
    item_t it;
    @(negedge clk_sys);
    old = m_dout;
    pin_clk_i = c; pin_rst_i = r; pin_din_i = d;
    if (c != m_oc) begin
      m_oc = c;
      if (c) begin
        m_rem = m_nxt;
        model_recompute(r, d);
      end
    end
    if (r != m_or || d != m_od) model_recompute(r, d);
    repeat (2) @(posedge clk_sys);
    #1;
    if (lat_chk) check(dout_o, old, "R8 early");
    @(posedge clk_sys);
    #1;
    it.exp = m_dout;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compare queued expectations at falling edges.
  always @(negedge clk_sys) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(dout_o, it.exp, it.tag);
    end
  end

  task automatic shift_bit(input logic d, input logic r);
    drive(1'b0, r, d, "R2/R3 data", 0);
    drive(1'b1, r, d, "R5 rise", 0);
    drive(1'b0, r, d, "R4 fall", 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_sys);
    #1;
    check(dout_o, 1'b0, "R1 reset");
    rst_sys_n = 1'b1;
    repeat (2) @(posedge clk_sys);
    #1;
    check(dout_o, 1'b0, "R1 after release");

    // R8 latency: din 1 gives 0 at remainder 0, then din 0 gives 1.
    drive(1'b0, 1'b0, 1'b1, "R6 din up", 0);
    drive(1'b0, 1'b0, 1'b0, "R8 latency", 1);

    // Directed stream 1,1,0 (remainders 1,0,0).
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b0, 1'b0);
    // Move to remainder 2: bits 1,0.
    shift_bit(1'b1, 1'b0);
    shift_bit(1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1, "R3 rem2 din1", 0);

    // R7: pin reset holds output, remainder zero after next rise.
    drive(1'b0, 1'b1, 1'b1, "R7 hold", 0);
    drive(1'b0, 1'b1, 1'b0, "R7 din ignored", 0);
    drive(1'b1, 1'b1, 1'b0, "R7 rise in reset", 0);
    drive(1'b0, 1'b1, 1'b0, "R7 fall", 0);
    drive(1'b0, 1'b0, 1'b0, "R7 release rem0", 0);

    // R9: clock rise and data change together.
    drive(1'b0, 1'b0, 1'b1, "R9 prep", 0);
    drive(1'b1, 1'b0, 1'b0, "R9 simultaneous", 0);
    drive(1'b0, 1'b0, 1'b1, "R9 after", 0);

    // Random streams with occasional pin reset.
    for (int i = 0; i < 300; i++) begin
      logic d, r;
      d = 1'($urandom_range(0, 1));
      r = ($urandom_range(0, 15) == 0);
      shift_bit(d, r);
      if ($urandom_range(0, 3) == 0)
        drive(1'b1, r, ~d, "R9 random", 0);
    end
    drive(1'b0, 1'b0, 1'b0, "R6 final", 0);
    repeat (3) @(negedge clk_sys);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule